// File: doc/BRIEF.md
# Clock Select and Idle-Mode Controller

This block sits between a small processor core and its clock tree. It holds an 8-bit system-mode register that software writes to pick the system clock, to enable fast wake-up and to choose between idle and sleep on a halt. The system clock is either a slow sub clock, which arrives as a one-cycle `sub_tick` strobe, or the high-speed clock divided by 1, 2, 4, 8, 16, 32 or 64. The chosen source leaves the block as the `sys_tick` clock-enable pulse.

A halt request moves the block from run mode into one of three low-power states. Two inputs and one register bit pick the state: the idle-enable bit, the oscillator keep-on input and, for the timer clock, the timer source input. The block drives the CPU clock enable, the high-speed oscillator enable and the peripheral timer clock enable to match. A wake event returns it to run mode. If the high-speed oscillator was stopped, the block either holds the CPU until the oscillator-ready count expires, or, with fast wake-up enabled, runs the CPU from the sub clock in the meantime. Changes of clock source take effect only on a boundary of the old source, so `sys_tick` never shows a cut-short period.

All pins are plain control and status levels; there is no streamed data path and therefore no valid/ready handshake.

Top module: `clksel_idle_ctrl`

## Requirements
- R1: After reset the register reads 8'h03. Clock select, fast-wake enable and both ready flags are 0. Idle-enable (bit 1) and high/low select (bit 0) are 1. The block is in run mode (pm_mode 0) with the CPU clock and oscillator enabled.
- R2: Bits 7..5 (clock select), bit 4 (fast-wake enable), bit 1 and bit 0 read back what was written. Bit 3 (low-speed ready) and bit 2 (high-speed ready) ignore writes. Bit 3 sets on the first sub_tick after reset and stays set.
- R3: The rate of sys_tick follows the register. With bit 0 = 1 it pulses every high-speed cycle. With bit 0 = 0, select codes 0 and 1 give the sub clock, and codes 2 to 7 give the high-speed clock divided by 64, 32, 16, 8, 4 and 2.
- R4: The high-speed ready flag sets READY_CYCLES cycles after the oscillator enable rises. It clears one cycle after the enable falls.
- R5: In run mode, a halt with idle-enable 1 and osc_keep_on 0 enters IDLE0 (pm_mode 1) on the next edge. In IDLE0 the CPU clock and the oscillator are disabled.
- R6: In IDLE0, tmr_clk_en equals tmr_src_sub: the timer runs from the sub clock and is stopped when it is fed from the divided system clock.
- R7: In run mode, a halt with idle-enable 1 and osc_keep_on 1 enters IDLE1 (pm_mode 2). The CPU clock is disabled, while the oscillator and timer clock stay enabled. The ready flag stays set.
- R8: In run mode, a halt with idle-enable 0 enters SLEEP (pm_mode 3) whatever osc_keep_on is. The CPU clock and the oscillator are disabled, and tmr_clk_en equals tmr_src_sub.
- R9: A wake from IDLE0 or SLEEP with a high-speed source and fast wake off enters WARMUP (pm_mode 4). The CPU clock stays off, and run mode and the CPU clock return READY_CYCLES+1 edges after the wake edge.
- R10: A wake from IDLE0 or SLEEP with a high-speed source and fast wake on enters FASTWAKE (pm_mode 5) at once with the CPU clock enabled. sys_tick follows sub_tick until run mode returns, READY_CYCLES+1 edges after the wake edge.
- R11: A wake from IDLE1, or from IDLE0 or SLEEP while the sub clock is selected, returns to run mode on the wake edge.
- R12: The active source changes only on a tick of the old source, or when the old source is a stopped high-speed clock. sys_tick never carries high-speed pulses while the oscillator is off, and once the block is back in run mode the selected rate returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value including ready flags |
| halt_req | input | 1 | Halt request from the core, one cycle |
| wake_evt | input | 1 | Wake event, one cycle |
| osc_keep_on | input | 1 | Keep the high-speed oscillator running in idle |
| tmr_src_sub | input | 1 | Timer clock source: 1 sub clock, 0 system clock divided by 4 |
| sub_tick | input | 1 | One-cycle strobe per sub clock period |
| cpu_clk_en | output | 1 | CPU clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| tmr_clk_en | output | 1 | Peripheral timer clock enable |
| sys_tick | output | 1 | System clock enable pulse from the active source |
| pm_mode | output | 3 | Power state: 0 run, 1 IDLE0, 2 IDLE1, 3 SLEEP, 4 WARMUP, 5 FASTWAKE |

## Verification
The assertions check these on every cycle: the outputs just after a halt is taken into IDLE0 or IDLE1, the rule that the ready flag only rises while the oscillator runs and drops once it stops, and the rule that the active clock source changes only on an old-source tick or a dead oscillator. The bench scenarios are needed to show the measured divide ratio for every select code, the read-only flag bits, the exact warm-up and fast-wake latencies, the timer clock's dependence on its source in IDLE0 and SLEEP, and that sys_tick tracks the sub clock during fast wake and during sleep.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE0 = 3'd1,
    ST_IDLE1 = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WARM  = 3'd4,
    ST_FAST  = 3'd5
  } pm_state_t;

  // Active source code: 0 = sub clock, n = high-speed divided by 2**(7-n)
  localparam int unsigned DIV_STAGES = 6;
  localparam logic [2:0] SRC_SUB  = 3'd0;
  localparam logic [2:0] SRC_FULL = 3'd7;

  function automatic logic [2:0] map_src(input logic hl_sel, input logic [2:0] cks);
    if (hl_sel) return SRC_FULL;
    else if (cks < 3'd2) return SRC_SUB;
    else return cks - 3'd1;
  endfunction

endpackage

// File: rtl/clksel_divider.sv
module clksel_divider #(
  parameter int unsigned STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [STAGES:0]   tick_vec
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_vec[0] = run;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign tick_vec[k] = run & (&cnt_q[k-1:0]);
  end
endmodule

// File: rtl/clksel_ready_timer.sv
module clksel_ready_timer #(
  parameter int unsigned READY_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_on,
  output logic ready
);
  localparam int unsigned CW = $clog2(READY_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(READY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!osc_on)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = (cnt_q == LIMIT);

  assert_ready_needs_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(osc_on));
  assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_on |=> !ready);
endmodule

// File: rtl/clksel_pm_fsm.sv
module clksel_pm_fsm
  import clksel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      wake_evt,
  input  logic      idle_en,
  input  logic      keep_on,
  input  logic      fast_en,
  input  logic      sub_sel,
  input  logic      hs_ready,
  output pm_state_t state
);
  pm_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: if (halt_req) begin
        if (!idle_en)     nxt = ST_SLEEP;
        else if (keep_on) nxt = ST_IDLE1;
        else              nxt = ST_IDLE0;
      end
      ST_IDLE1: if (wake_evt) nxt = ST_RUN;
      ST_IDLE0, ST_SLEEP: if (wake_evt) begin
        if (sub_sel)      nxt = ST_RUN;
        else if (fast_en) nxt = ST_FAST;
        else              nxt = ST_WARM;
      end
      ST_WARM, ST_FAST: if (hs_ready) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/clksel_idle_ctrl.sv
module clksel_idle_ctrl
  import clksel_pkg::*;
#(
  parameter int unsigned READY_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       halt_req,
  input  logic       wake_evt,
  input  logic       osc_keep_on,
  input  logic       tmr_src_sub,
  input  logic       sub_tick,
  output logic       cpu_clk_en,
  output logic       hosc_en,
  output logic       tmr_clk_en,
  output logic       sys_tick,
  output logic [2:0] pm_mode
);
  // Writable fields
  logic [2:0] cks_q;
  logic       fast_q, idle_q, hl_q;
  logic       sub_seen_q;
  logic       hs_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cks_q  <= 3'd0;
      fast_q <= 1'b0;
      idle_q <= 1'b1;
      hl_q   <= 1'b1;
    end else if (reg_wr) begin
      cks_q  <= reg_wdata[7:5];
      fast_q <= reg_wdata[4];
      idle_q <= reg_wdata[1];
      hl_q   <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sub_seen_q <= 1'b0;
    else if (sub_tick) sub_seen_q <= 1'b1;
  end

  assign reg_rdata = {cks_q, fast_q, sub_seen_q, hs_ready, idle_q, hl_q};

  // Power state machine
  pm_state_t  st;
  logic [2:0] cfg_src;
  assign cfg_src = map_src(hl_q, cks_q);

  clksel_pm_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req),
    .wake_evt (wake_evt),
    .idle_en  (idle_q),
    .keep_on  (osc_keep_on),
    .fast_en  (fast_q),
    .sub_sel  (cfg_src == SRC_SUB),
    .hs_ready (hs_ready),
    .state    (st)
  );

  assign pm_mode    = st;
  assign cpu_clk_en = (st == ST_RUN) || (st == ST_FAST);
  assign hosc_en    = (st == ST_RUN) || (st == ST_FAST) || (st == ST_WARM) || (st == ST_IDLE1);
  assign tmr_clk_en = hosc_en ? 1'b1 : tmr_src_sub;

  clksel_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_on (hosc_en),
    .ready  (hs_ready)
  );

  logic [DIV_STAGES:0] tick_vec;
  clksel_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (hosc_en),
    .tick_vec (tick_vec)
  );

  // Clock source handover
  logic [2:0] act_src_q, req_src, tap_sel;
  logic       act_tick, src_dead;

  assign req_src  = ((st == ST_RUN) || (st == ST_IDLE1)) ? cfg_src : SRC_SUB;
  assign tap_sel  = SRC_FULL - act_src_q;
  assign act_tick = (act_src_q == SRC_SUB) ? sub_tick : tick_vec[tap_sel];
  assign src_dead = (act_src_q != SRC_SUB) && !hosc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_src_q <= SRC_FULL;
    else if ((req_src != act_src_q) && (act_tick || src_dead)) act_src_q <= req_src;
  end

  assign sys_tick = act_tick;

  assert_idle0_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && halt_req && idle_q && !osc_keep_on) |=> (!cpu_clk_en && !hosc_en));
  assert_idle1_keeps_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && halt_req && idle_q && osc_keep_on) |=> (!cpu_clk_en && hosc_en && tmr_clk_en));
  assert_clean_handover_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src_q != $past(act_src_q)) |-> $past(act_tick || src_dead));
  assert_no_hs_tick_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick && act_src_q != SRC_SUB) |-> hosc_en);
endmodule

// File: tb/sim_clksel_idle_ctrl.sv
module sim_clksel_idle_ctrl;
  localparam int RDY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic halt_req = 1'b0, wake_evt = 1'b0, osc_keep_on = 1'b0, tmr_src_sub = 1'b0, sub_tick = 1'b0;
  logic cpu_clk_en, hosc_en, tmr_clk_en, sys_tick;
  logic [2:0] pm_mode;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksel_idle_ctrl #(.READY_CYCLES(RDY)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_req(halt_req), .wake_evt(wake_evt), .osc_keep_on(osc_keep_on), .tmr_src_sub(tmr_src_sub),
    .sub_tick(sub_tick), .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en), .tmr_clk_en(tmr_clk_en),
    .sys_tick(sys_tick), .pm_mode(pm_mode)
  );

  // Sub clock: one strobe every 10 cycles
  initial begin
    forever begin
      repeat (9) @(negedge clk);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0; #1;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (sys_tick) c++;
    end
  endtask

  initial begin
    int c, first, mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R1 reset rdata", reg_rdata, 8'h03);
    chk("R1 reset mode", pm_mode, 0);
    chk("R1 reset cpu/osc", {cpu_clk_en, hosc_en}, 2'b11);

    repeat (RDY + 20) @(negedge clk); #1;
    chk("R4 ready flags set", reg_rdata, 8'h0F);

    wr(8'h00); chk("R2 flags ignore write 0", reg_rdata, 8'h0C);
    wr(8'hF3); chk("R2 full write", reg_rdata, 8'hFF);
    wr(8'h53); chk("R2 fields readback", reg_rdata, 8'h5F);

    // R3: divide-ratio sweep
    for (int cks = 0; cks < 8; cks++) begin
      wr(8'((cks << 5) | 2));
      repeat (150) @(negedge clk);
      count_ticks(320, c);
      chk($sformatf("R3 rate cks=%0d", cks), c, (cks < 2) ? 32 : (320 >> (8 - cks)));
    end
    wr(8'h03);
    repeat (150) @(negedge clk);
    count_ticks(320, c);
    chk("R3 rate undivided", c, 320);

    // IDLE0
    osc_keep_on = 1'b0; tmr_src_sub = 1'b1;
    pulse_halt();
    chk("R5 idle0 mode", pm_mode, 1);
    chk("R5 idle0 cpu/osc", {cpu_clk_en, hosc_en}, 2'b00);
    chk("R6 idle0 timer sub", tmr_clk_en, 1);
    tmr_src_sub = 1'b0; #1;
    chk("R6 idle0 timer sys/4", tmr_clk_en, 0);
    repeat (3) @(negedge clk); #1;
    chk("R4 ready clears", reg_rdata[2], 0);

    // R9: wake without fast wake
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0; #1;
    chk("R9 warmup mode", pm_mode, 4);
    first = (cpu_clk_en) ? 0 : -1;
    for (int k = 1; k < 40 && first < 0; k++) begin
      @(negedge clk); #1;
      if (cpu_clk_en) first = k;
    end
    chk("R9 warmup latency", first, RDY + 1);
    chk("R9 run after warmup", pm_mode, 0);

    // R10: fast wake
    wr(8'h13);
    repeat (RDY + 70) @(negedge clk);
    pulse_halt();
    repeat (5) @(negedge clk);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0; #1;
    chk("R10 fast mode", pm_mode, 5);
    chk("R10 fast cpu on", cpu_clk_en, 1);
    mism = (sys_tick != sub_tick) ? 1 : 0;
    for (int k = 1; k <= RDY; k++) begin
      @(negedge clk); #1;
      if (sys_tick != sub_tick) mism++;
    end
    chk("R10 sys follows sub", mism, 0);
    @(negedge clk); #1;
    chk("R10 run after fast", pm_mode, 0);
    repeat (30) @(negedge clk);
    count_ticks(64, c);
    chk("R12 rate back after handover", c, 64);

    // IDLE1
    osc_keep_on = 1'b1; tmr_src_sub = 1'b0;
    pulse_halt();
    chk("R7 idle1 mode", pm_mode, 2);
    chk("R7 idle1 cpu/osc/tmr", {cpu_clk_en, hosc_en, tmr_clk_en}, 3'b011);
    repeat (5) @(negedge clk); #1;
    chk("R7 ready kept", reg_rdata[2], 1);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0; #1;
    chk("R11 idle1 wake direct", {pm_mode, cpu_clk_en}, 4'b0001);

    // SLEEP
    wr(8'h01);
    tmr_src_sub = 1'b1;
    pulse_halt();
    chk("R8 sleep mode", pm_mode, 3);
    chk("R8 sleep cpu/osc/tmr", {cpu_clk_en, hosc_en, tmr_clk_en}, 3'b001);
    tmr_src_sub = 1'b0; #1;
    chk("R8 sleep timer sys/4", tmr_clk_en, 0);
    repeat (2) @(negedge clk);
    mism = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #1;
      if (sys_tick != sub_tick) mism++;
    end
    chk("R12 no hs ticks osc off", mism, 0);
    wr(8'h00);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0; #1;
    chk("R11 sub wake direct", {pm_mode, cpu_clk_en}, 4'b0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule